// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is a small bank of configuration registers reached through a plain register port: address, write data, write strobe, read strobe and read data. It holds one global control register, a set of per-fan duty registers and a set of 8-bit limit registers. The control register drives the block's control outputs: monitor enable, force full speed, spin-up hold mode and bus timeout disable. The bank also produces the final per-fan duty values that go to the PWM generator.

Writing a 1 to the lock bit freezes every protected register until the next reset. The lock bit is write-once. Some bits stay writable after the lock is set: the monitoring start bit and the force-full-speed bit, along with the duty registers. The limit registers, the spin-up hold bit and the timeout-disable bit are protected. A write to a protected register after the lock is accepted without error and leaves the register unchanged. While monitoring is off, every fan duty output is forced to full scale. The programmed limits are kept and take effect again when monitoring restarts.

Top module: `cfg_lock_bank`

## Requirements
- R1: After reset, the control register reads 0x04, every duty register reads 0x40, every limit register reads 0x00, monEn is 0 and every fanDuty byte is 0xFF.
- R2: The control register fields are: bit 0 start, bit 1 lock, bit 2 ready, bit 3 force full speed, bit 4 spin-up hold, bit 5 timeout disable. Bits 7:6 are reserved, read as 0 and ignore writes.
- R3: rdData takes the addressed value at the clock edge where rdEn is sampled high. The address map is: 0 control, 1..NUM_FANS duty, then NUM_LIMITS limit registers. Any other address reads 0 and ignores writes.
- R4: The lock bit is write-once. After it is set, writing 0 does not clear it. Only reset clears it.
- R5: With lock set, writes to limit registers leave them unchanged.
- R6: With lock set, the spin-up hold and timeout-disable bits keep their values. A single write that sets lock still updates them, because the lock applies from the next write.
- R7: With lock set, the start bit, the force-full-speed bit and the duty registers stay writable.
- R8: The ready bit reads 1 and cannot be changed by a write.
- R9: While start is 0, every fanDuty byte is 0xFF, and the limit registers keep and read back their programmed values.
- R10: While start is 1, each fanDuty byte is 0xFF if force full speed is 1, and otherwise equals its duty register. Fan 0 is in bits 7:0.
- R11: monEn, forceFull, spinHold and tmoDisable follow control bits 0, 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| monEn | output | 1 | Monitoring enabled |
| forceFull | output | 1 | Run all fans at full speed |
| spinHold | output | 1 | Hold PWM high for the whole spin-up timeout |
| tmoDisable | output | 1 | Bus timeout disabled |
| fanDuty | output | 8*NUM_FANS | Effective duty per fan |

## Verification
The hardest case is a control write that arrives once the lock is already set. That one write carries both protected and exempt bits, so a single access has to update start and force full speed while spin-up hold, timeout disable and the lock stay as they are. The stimulus first sets the lock together with the protected bits in one write. It then writes the inverse pattern and reads the register back, and it also checks the control outputs. Writes to the limits after the lock, followed by a second reset, confirm that the freeze holds and that it ends only with reset.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int DATA_W        = 8;
  localparam int BIT_START     = 0;
  localparam int BIT_LOCK      = 1;
  localparam int BIT_READY     = 2;
  localparam int BIT_FORCE     = 3;
  localparam int BIT_SPIN      = 4;
  localparam int BIT_TMO       = 5;
  localparam logic [7:0] DUTY_RESET  = 8'h40;
  localparam logic [7:0] LIMIT_RESET = 8'h00;
  localparam logic [7:0] DUTY_MAX    = 8'hFF;

  typedef struct packed {
    logic ctrlWe;
    logic dutyWe;
    logic limitWe;
    logic rdCtrl;
    logic rdDuty;
    logic rdLimit;
    logic rdAny;
  } bankStrobe_t;
endpackage

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int NUM_FANS   = 3,
  parameter int NUM_LIMITS = 6,
  parameter int IDX_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              lockQ,
  output bankStrobe_t       strobe,
  output logic [IDX_W-1:0]  idx
);
  localparam int DUTY_BASE  = 1;
  localparam int LIMIT_BASE = DUTY_BASE + NUM_FANS;
  localparam int LIMIT_END  = LIMIT_BASE + NUM_LIMITS;

  logic              isCtrl, isDuty, isLimit;
  logic [ADDR_W-1:0] dutyOff, limitOff;

  always_comb begin
    isCtrl   = (addr == '0);
    isDuty   = (addr >= ADDR_W'(DUTY_BASE)) && (addr < ADDR_W'(LIMIT_BASE));
    isLimit  = (addr >= ADDR_W'(LIMIT_BASE)) && (addr < ADDR_W'(LIMIT_END));
    dutyOff  = addr - ADDR_W'(DUTY_BASE);
    limitOff = addr - ADDR_W'(LIMIT_BASE);
    idx      = isDuty ? dutyOff[IDX_W-1:0] : limitOff[IDX_W-1:0];

    strobe.ctrlWe  = wrEn && isCtrl;
    strobe.dutyWe  = wrEn && isDuty;
    strobe.limitWe = wrEn && isLimit && !lockQ;
    strobe.rdCtrl  = rdEn && isCtrl;
    strobe.rdDuty  = rdEn && isDuty;
    strobe.rdLimit = rdEn && isLimit;
    strobe.rdAny   = rdEn;
  end

  // R3: at most one register class is selected per access
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.ctrlWe, strobe.dutyWe, strobe.limitWe}));
  p_read_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.rdCtrl, strobe.rdDuty, strobe.rdLimit}));
endmodule

// File: rtl/cfg_lock_datapath.sv
module cfg_lock_datapath
  import cfg_lock_pkg::*;
#(
  parameter int NUM_FANS   = 3,
  parameter int NUM_LIMITS = 6,
  parameter int IDX_W      = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  bankStrobe_t            strobe,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             wrData,
  output logic                   lockQ,
  output logic [7:0]             rdData,
  output logic                   monEn,
  output logic                   forceFull,
  output logic                   spinHold,
  output logic                   tmoDisable,
  output logic [8*NUM_FANS-1:0]  fanDuty
);
  logic startQ, readyQ, forceQ, spinQ, tmoQ;
  logic [7:0] dutyQ  [NUM_FANS];
  logic [7:0] limitQ [NUM_LIMITS];
  logic [8*NUM_LIMITS-1:0] limitFlat;
  logic [7:0] ctrlView, dutyView, limitView, rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ <= 1'b0;
      lockQ  <= 1'b0;
      readyQ <= 1'b1;
      forceQ <= 1'b0;
      spinQ  <= 1'b0;
      tmoQ   <= 1'b0;
    end else if (strobe.ctrlWe) begin
      startQ <= wrData[BIT_START];
      forceQ <= wrData[BIT_FORCE];
      lockQ  <= lockQ | wrData[BIT_LOCK];
      if (!lockQ) begin
        spinQ <= wrData[BIT_SPIN];
        tmoQ  <= wrData[BIT_TMO];
      end
    end
  end

  for (genvar i = 0; i < NUM_FANS; i++) begin : g_duty
    always_ff @(posedge clk) begin
      if (rst)                                   dutyQ[i] <= DUTY_RESET;
      else if (strobe.dutyWe && idx == IDX_W'(i)) dutyQ[i] <= wrData;
    end
    assign fanDuty[8*i +: 8] = (!startQ || forceQ) ? DUTY_MAX : dutyQ[i];
  end

  for (genvar j = 0; j < NUM_LIMITS; j++) begin : g_limit
    always_ff @(posedge clk) begin
      if (rst)                                    limitQ[j] <= LIMIT_RESET;
      else if (strobe.limitWe && idx == IDX_W'(j)) limitQ[j] <= wrData;
    end
    assign limitFlat[8*j +: 8] = limitQ[j];
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[BIT_START] = startQ;
    ctrlView[BIT_LOCK]  = lockQ;
    ctrlView[BIT_READY] = readyQ;
    ctrlView[BIT_FORCE] = forceQ;
    ctrlView[BIT_SPIN]  = spinQ;
    ctrlView[BIT_TMO]   = tmoQ;
    dutyView  = '0;
    limitView = '0;
    for (int k = 0; k < NUM_FANS; k++)
      if (idx == IDX_W'(k)) dutyView = dutyQ[k];
    for (int k = 0; k < NUM_LIMITS; k++)
      if (idx == IDX_W'(k)) limitView = limitQ[k];
    rdNext = strobe.rdCtrl  ? ctrlView  :
             strobe.rdDuty  ? dutyView  :
             strobe.rdLimit ? limitView : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst)               rdData <= '0;
    else if (strobe.rdAny) rdData <= rdNext;
  end

  assign monEn      = startQ;
  assign forceFull  = forceQ;
  assign spinHold   = spinQ;
  assign tmoDisable = tmoQ;

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    lockQ |=> lockQ);
  p_limits_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    lockQ |=> $stable(limitFlat));
  p_prot_bits_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    lockQ |=> $stable({spinQ, tmoQ}));
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.rdCtrl |=> (rdData[7:6] == 2'b00));
  p_ready_held_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.ctrlWe |=> readyQ);
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int NUM_FANS   = 3,
  parameter int NUM_LIMITS = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wrData,
  input  logic                  wrEn,
  input  logic                  rdEn,
  output logic [7:0]            rdData,
  output logic                  monEn,
  output logic                  forceFull,
  output logic                  spinHold,
  output logic                  tmoDisable,
  output logic [8*NUM_FANS-1:0] fanDuty
);
  localparam int MAX_REGS = (NUM_FANS > NUM_LIMITS) ? NUM_FANS : NUM_LIMITS;
  localparam int IDX_W    = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;

  bankStrobe_t      strobe;
  logic [IDX_W-1:0] idx;
  logic             lockQ;

  cfg_lock_ctrl #(
    .ADDR_W(ADDR_W), .NUM_FANS(NUM_FANS), .NUM_LIMITS(NUM_LIMITS), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .lockQ(lockQ), .strobe(strobe), .idx(idx)
  );

  cfg_lock_datapath #(
    .NUM_FANS(NUM_FANS), .NUM_LIMITS(NUM_LIMITS), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .idx(idx), .wrData(wrData),
    .lockQ(lockQ), .rdData(rdData), .monEn(monEn), .forceFull(forceFull),
    .spinHold(spinHold), .tmoDisable(tmoDisable), .fanDuty(fanDuty)
  );
endmodule

// File: tb/sim_cfg_lock_bank.sv
module sim_cfg_lock_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] rdData;
  logic monEn, forceFull, spinHold, tmoDisable;
  logic [23:0] fanDuty;

  int checks = 0, fails = 0, cycles = 0;
  logic rdSeen = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  cfg_lock_bank u0 (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .monEn(monEn), .forceFull(forceFull), .spinHold(spinHold),
    .tmoDisable(tmoDisable), .fanDuty(fanDuty)
  );

  always @(posedge clk) rdSeen <= rdEn;

  always @(negedge clk) begin
    if (rdSeen) begin
      item_t it;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL %s: read data %h with no expected item", "R3", rdData);
      end else begin
        it = q.pop_front();
        if (rdData !== it.exp) begin
          fails++;
          $display("FAIL %s: rdData=%h expected %h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: cycles=%0d expected <=20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(negedge clk); addr = a; rdEn = 1'b1; q.push_back(it);
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic checkOut(input logic [27:0] exp, input string tag);
    logic [27:0] act;
    act = {monEn, forceFull, spinHold, tmoDisable, fanDuty};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkOut({4'b0000, 24'hFFFFFF}, "R1");
    doRead(4'd0, 8'h04, "R1");
    doRead(4'd1, 8'h40, "R1");
    doRead(4'd4, 8'h00, "R1");

    // R2 R8: reserved bits and ready ignore writes
    doWrite(4'd0, 8'hF9);
    doRead(4'd0, 8'h3D, "R2 R8");
    @(negedge clk);
    checkOut({4'b1111, 24'hFFFFFF}, "R11 R10");

    // R10: duty path with start on, force off
    doWrite(4'd1, 8'h11);
    doWrite(4'd2, 8'h22);
    doWrite(4'd3, 8'h33);
    doWrite(4'd0, 8'h01);
    doRead(4'd0, 8'h05, "R2");
    @(negedge clk);
    checkOut({4'b1000, 24'h332211}, "R10");

    // limits and unmapped addresses
    for (int i = 0; i < 6; i++) doWrite(4'(4 + i), 8'hA4 + 8'(i));
    for (int i = 0; i < 6; i++) doRead(4'(4 + i), 8'hA4 + 8'(i), "R3");
    doWrite(4'd12, 8'h55);
    doRead(4'd12, 8'h00, "R3");

    // R9: monitoring off forces max duty, limits kept
    doWrite(4'd0, 8'h00);
    @(negedge clk);
    checkOut({4'b0000, 24'hFFFFFF}, "R9");
    doRead(4'd5, 8'hA5, "R9");
    doWrite(4'd0, 8'h01);
    @(negedge clk);
    checkOut({4'b1000, 24'h332211}, "R9");

    // R6: the write that sets lock also sets protected bits
    doWrite(4'd0, 8'h33);
    doRead(4'd0, 8'h37, "R6");
    // R4 R6 R7: after lock
    doWrite(4'd0, 8'h09);
    doRead(4'd0, 8'h3F, "R4 R6 R7");
    @(negedge clk);
    checkOut({4'b1111, 24'hFFFFFF}, "R7");
    doWrite(4'd0, 8'h00);
    doRead(4'd0, 8'h36, "R7 R4");
    @(negedge clk);
    checkOut({4'b0011, 24'hFFFFFF}, "R7");

    // R5: limits frozen, R7: duty still writable
    doWrite(4'd4, 8'h00);
    doRead(4'd4, 8'hA4, "R5");
    doWrite(4'd9, 8'h12);
    doRead(4'd9, 8'hA9, "R5");
    doWrite(4'd1, 8'h99);
    doRead(4'd1, 8'h99, "R7");

    // R4: only reset clears lock
    doReset();
    doRead(4'd0, 8'h04, "R4");
    doWrite(4'd4, 8'h5A);
    doRead(4'd4, 8'h5A, "R4");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R3: %0d reads pending expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule